// File: doc/BRIEF.md
# Byte-Stepped Two-Wire Bus Master

This block is a master for a two-wire serial bus (clock line and data line, both open drain) that software moves forward one step at a time. Software writes an 8-bit control register to ask for a START, a STOP, or one byte transfer. The block places the matching conditions on the lines. When the step ends it raises a flag bit in the control register and loads an 8-bit status code that says what happened. A byte to transmit is placed in the 8-bit data register beforehand, and a received byte is left there afterwards.

Bit timing comes from a one-cycle `tick` input supplied by an external divider. A parameter sets how many ticks make half a bit period. The interrupt output is high while interrupts are enabled and the status is anything other than idle. The block does not provide multi-master arbitration or slave operation.

Control register bits are: 7 spare (stored and read back), 6 enable, 5 start, 4 stop, 3 step flag, 2 acknowledge-on-receive. Bits 1:0 always read 0. On read-back, bit 5 is high while a START sequence runs and bit 4 is high while a STOP sequence runs.

Top module: `i2cb_master`

## Requirements
- R1: After reset the status reads 0xF8, the control and data registers read 0x00, `irq` is low and neither line is driven.
- R2: A control write with bit 6 = 1, bit 5 = 1 and bit 3 = 0, made while no transfer is open and both lines are high, pulls the data line low while the clock line is high, then pulls the clock line low. It then sets status 0x08 and sets bit 3.
- R3: The same write while a transfer is open produces a repeated START: the data line is released, then the clock line, then the data line is pulled low. The status becomes 0x10 and bit 3 is set.
- R4: The first byte after any START is the address byte. It is sent MSB first from the data register, and its bit 0 selects read (1) or write (0). If the target acknowledges, the status is 0x18 for a write address and 0x40 for a read address.
- R5: In write mode, a control write with bit 6 = 1 and bits 5, 4, 3 = 0 shifts the data register out MSB first. An acknowledged byte yields status 0x28.
- R6: A NACK is reported as 0x20 after a write address, 0x48 after a read address, and 0x30 after a write data byte.
- R7: In read mode the same write shifts in one byte MSB first and stores it in the data register. The master answers ACK if bit 2 was written as 1 (status 0x50) and NACK otherwise (status 0x58).
- R8: A control write with bit 6 = 1, bit 4 = 1, bit 5 = 0 and bit 3 = 0, while a transfer is open, releases the data line while the clock line is high. Afterwards both lines are released, the status is 0xF8 and bit 4 reads 0.
- R9: `irq` equals `irq_en` AND (status != 0xF8).
- R10: A START request made while either line is low drives nothing, leaves the status at 0xF8 and sets bit 3.
- R11: A control write with bit 6 = 0, or with bit 3 written as 1, starts no bus activity and leaves the status and the lines unchanged.
- R12: Register writes made while a bus step is running are ignored.
- R13: Within a byte, every clock-line high time and low time lasts HALF_TICKS ticks. The data line is sampled at the end of each high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle timing pulse from the divider |
| irq_en | input | 1 | Interrupt enable |
| wr_ctl | input | 1 | Write strobe for the control register |
| wr_data | input | 1 | Write strobe for the data register |
| wdata | input | 8 | Write value |
| ctl_q | output | 8 | Control register read-back |
| data_q | output | 8 | Data register read-back |
| stat_q | output | 8 | Status code |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sensed level of the clock line |
| sda_in | input | 1 | Sensed level of the data line |
| scl_lo | output | 1 | Pull the clock line low |
| sda_lo | output | 1 | Pull the data line low |

## Verification
A bench target model acknowledges only its own address and can refuse data. This exposes a design that mixes up the four NACK codes or reports ACK codes regardless of the answer. Reads with and without master acknowledge catch a design that gets the last-byte NACK or the 0x58 code wrong. Repeated START and START against a held-low line catch a design that reports 0x08 in place of 0x10, or that drives the bus when it should refuse. Measuring clock high and low widths, and writing registers while a byte is in flight, expose uneven bit timing and a data register that gets overwritten mid-transfer.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int B_CE  = 7;
  localparam int B_EN  = 6;
  localparam int B_STA = 5;
  localparam int B_STO = 4;
  localparam int B_FLG = 3;
  localparam int B_AAK = 2;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RESTART = 8'h10;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  localparam int BYTE_STEPS = 18;

  typedef enum logic [2:0] {SQ_IDLE, SQ_START, SQ_RSTART, SQ_BYTE, SQ_STOP} seq_e;

  // Outcome code of a finished byte step.
  function automatic logic [7:0] byte_code(input logic is_addr, input logic is_rd,
                                           input logic acked);
    logic [7:0] c;
    if (is_addr) c = is_rd ? 8'h40 : 8'h18;
    else         c = is_rd ? 8'h50 : 8'h28;
    if (!acked) c = c + 8'h08;
    return c;
  endfunction

  // Nine bits placed on the data line, MSB first; 1 means released.
  function automatic logic [8:0] byte_frame(input logic rd_data, input logic [7:0] txb,
                                            input logic give_ack);
    return rd_data ? {8'hFF, ~give_ack} : {txb, 1'b1};
  endfunction
endpackage

// File: rtl/i2cb_halftick.sv
module i2cb_halftick #(
  parameter int HALF_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clear,
  output logic hstep
);
  localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt;

  assign hstep = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (tick)   cnt <= hstep ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/i2cb_shift9.sv
module i2cb_shift9 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [8:0] frame_in,
  input  logic       adv,
  input  logic       sin,
  output logic       nxt_bit,
  output logic [7:0] rx_byte
);
  logic [8:0] fr;

  assign nxt_bit = fr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr      <= '1;
      rx_byte <= '0;
    end else if (load) begin
      fr      <= frame_in;
      rx_byte <= '0;
    end else if (adv) begin
      fr      <= {fr[7:0], 1'b1};
      rx_byte <= {rx_byte[6:0], sin};
    end
  end
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master
  import i2cb_pkg::*;
#(
  parameter int HALF_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       irq_en,
  input  logic       wr_ctl,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  output logic [7:0] ctl_q,
  output logic [7:0] data_q,
  output logic [7:0] stat_q,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_lo,
  output logic       sda_lo
);
  localparam int SW = $clog2(BYTE_STEPS);
  localparam logic [SW-1:0] LAST_BYTE_STEP = SW'(BYTE_STEPS - 1);

  seq_e          sq;
  logic [SW-1:0] step;
  logic          active, addr_ph, rd_mode;
  logic          ce, en, aak, iflg;
  logic [7:0]    data_r, stat_r;

  // Named internal events for the assertions.
  logic busy, wr_ok, go, bus_free;
  logic ev_start, ev_refuse, ev_rstart, ev_stop, ev_byte, launch;
  logic hstep, adv, last_step, seq_done;
  logic start_done, rstart_done, stop_done, byte_done;
  logic nxt_bit, byte_rd, acked;
  logic [7:0] rx_byte;
  logic [8:0] frame_new;

  assign busy      = (sq != SQ_IDLE);
  assign wr_ok     = wr_ctl && !busy;
  assign go        = wr_ok && wdata[B_EN] && !wdata[B_FLG];
  assign bus_free  = scl_in && sda_in;
  assign ev_start  = go && wdata[B_STA] && !active && bus_free;
  assign ev_refuse = go && wdata[B_STA] && !active && !bus_free;
  assign ev_rstart = go && wdata[B_STA] && active;
  assign ev_stop   = go && !wdata[B_STA] && wdata[B_STO] && active;
  assign ev_byte   = go && !wdata[B_STA] && !wdata[B_STO] && active;
  assign launch    = ev_start || ev_rstart || ev_stop || ev_byte;

  assign frame_new = byte_frame(rd_mode && !addr_ph, data_r, wdata[B_AAK]);
  assign byte_rd   = addr_ph ? data_r[0] : rd_mode;
  assign acked     = !sda_in;

  always_comb begin
    unique case (sq)
      SQ_START:  last_step = (step == '0);
      SQ_RSTART: last_step = (step == SW'(2));
      SQ_STOP:   last_step = (step == SW'(1));
      SQ_BYTE:   last_step = (step == LAST_BYTE_STEP);
      default:   last_step = 1'b0;
    endcase
  end

  assign seq_done    = busy && hstep && last_step;
  assign adv         = (sq == SQ_BYTE) && hstep && step[0];
  assign start_done  = seq_done && (sq == SQ_START);
  assign rstart_done = seq_done && (sq == SQ_RSTART);
  assign stop_done   = seq_done && (sq == SQ_STOP);
  assign byte_done   = seq_done && (sq == SQ_BYTE);

  i2cb_halftick #(.HALF_TICKS(HALF_TICKS)) u_half (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(launch), .hstep(hstep)
  );

  i2cb_shift9 u_shift (
    .clk(clk), .rst_n(rst_n), .load(ev_byte), .frame_in(frame_new),
    .adv(adv), .sin(sda_in), .nxt_bit(nxt_bit), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq <= SQ_IDLE; step <= '0; active <= 1'b0; addr_ph <= 1'b0; rd_mode <= 1'b0;
      ce <= 1'b0; en <= 1'b0; aak <= 1'b0; iflg <= 1'b0;
      data_r <= '0; stat_r <= ST_IDLE; scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      if (wr_ok) begin
        ce  <= wdata[B_CE];
        en  <= wdata[B_EN];
        aak <= wdata[B_AAK];
        if (!wdata[B_FLG]) iflg <= 1'b0;
      end
      if (wr_data && !busy) data_r <= wdata;
      if (ev_refuse) iflg <= 1'b1;
      if (ev_start)  begin sq <= SQ_START;  sda_lo <= 1'b1; end
      if (ev_rstart) begin sq <= SQ_RSTART; sda_lo <= 1'b0; end
      if (ev_stop)   begin sq <= SQ_STOP;   sda_lo <= 1'b1; end
      if (ev_byte)   begin sq <= SQ_BYTE;   sda_lo <= ~frame_new[8]; end
      if (launch) step <= '0;

      if (busy && hstep) begin
        step <= step + 1'b1;
        unique case (sq)
          SQ_START: scl_lo <= 1'b1;
          SQ_RSTART: begin
            if (step == '0)         scl_lo <= 1'b0;
            else if (step == SW'(1)) sda_lo <= 1'b1;
            else                     scl_lo <= 1'b1;
          end
          SQ_STOP: begin
            if (step == '0) scl_lo <= 1'b0;
            else            sda_lo <= 1'b0;
          end
          SQ_BYTE: begin
            if (!step[0]) scl_lo <= 1'b0;
            else begin
              scl_lo <= 1'b1;
              sda_lo <= last_step ? 1'b0 : ~nxt_bit;
            end
          end
          default: ;
        endcase

        if (seq_done) begin
          sq <= SQ_IDLE;
          unique case (sq)
            SQ_START:  begin stat_r <= ST_START;   iflg <= 1'b1; active <= 1'b1; addr_ph <= 1'b1; end
            SQ_RSTART: begin stat_r <= ST_RESTART; iflg <= 1'b1; addr_ph <= 1'b1; end
            SQ_STOP:   begin stat_r <= ST_IDLE;    active <= 1'b0; addr_ph <= 1'b0; end
            SQ_BYTE: begin
              stat_r  <= byte_code(addr_ph, byte_rd, acked);
              iflg    <= 1'b1;
              addr_ph <= 1'b0;
              if (addr_ph) rd_mode <= data_r[0];
              else if (rd_mode) data_r <= rx_byte;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign ctl_q  = {ce, en, (sq == SQ_START) || (sq == SQ_RSTART), (sq == SQ_STOP),
                   iflg, aak, 2'b00};
  assign data_q = data_r;
  assign stat_q = stat_r;
  assign irq    = irq_en && (stat_r != ST_IDLE);

  assert_start_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_done |=> (stat_q == ST_START) && ctl_q[B_FLG] && scl_lo);

  assert_rstart_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_done |=> (stat_q == ST_RESTART) && ctl_q[B_FLG]);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> (stat_q == ST_IDLE) && !scl_lo && !sda_lo);

  assert_refuse_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refuse |=> (stat_q == ST_IDLE) && !scl_lo && !sda_lo && ctl_q[B_FLG]);

  assert_scl_steady_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hstep) |=> $stable(scl_lo));

  assert_busy_data_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> $stable(data_q));

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq == SQ_BYTE) |-> (step <= LAST_BYTE_STEP));

  assert_launch_clears_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !ctl_q[B_FLG]);
endmodule

// File: tb/i2cb_master_bench.sv
module i2cb_master_bench;
  localparam int HALF = 2;
  localparam int TDIV = 4;
  localparam logic [6:0] SLV = 7'h2D;

  logic clk = 1'b0, rst_n = 1'b0, tick, irq_en = 1'b0;
  logic wr_ctl = 1'b0, wr_data = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctl_q, data_q, stat_q;
  logic irq, scl_lo, sda_lo;
  logic hold_sda_low = 1'b0, slv_lo = 1'b0, nack_data = 1'b0;
  logic scl_bus, sda_bus;
  int tcnt = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
  assign tick = (tcnt == TDIV - 1);

  assign scl_bus = !scl_lo;
  assign sda_bus = !sda_lo && !slv_lo && !hold_sda_low;

  i2cb_master #(.HALF_TICKS(HALF)) u_i2cb_master (
    .clk(clk), .rst_n(rst_n), .tick(tick), .irq_en(irq_en),
    .wr_ctl(wr_ctl), .wr_data(wr_data), .wdata(wdata),
    .ctl_q(ctl_q), .data_q(data_q), .stat_q(stat_q), .irq(irq),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_lo(scl_lo), .sda_lo(sda_lo)
  );

  function automatic logic [7:0] rdb(input int k);
    return 8'(8'h3C + k * 71);
  endfunction

  function automatic logic [7:0] exp_code(input bit is_addr, input bit rd, input bit ack);
    int base;
    base = is_addr ? (rd ? 64 : 24) : (rd ? 80 : 40);
    return 8'(base + (ack ? 0 : 8));
  endfunction

  // Target model on the bus.
  bit ps, pd, is_addr, s_rd, s_sel, mnack, drv;
  int bc, rd_k, cyc, tedge, hw, lw;
  logic [7:0] shreg, txb, addr_seen, last_rx;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ps = 1; pd = 1; bc = 0; is_addr = 0; s_rd = 0; s_sel = 0; drv = 0; slv_lo <= 1'b0;
    end else begin
      if (ps && scl_bus && pd && !sda_bus) begin
        bc = 0; is_addr = 1; drv = 0; rd_k = 0; slv_lo <= 1'b0;
      end else if (ps && scl_bus && !pd && sda_bus) begin
        bc = 0; is_addr = 0; s_sel = 0; drv = 0; slv_lo <= 1'b0;
      end else if (!ps && scl_bus) begin
        bc++;
        if (bc <= 8) shreg = {shreg[6:0], sda_bus}; else mnack = sda_bus;
        if (bc == 3) lw = cyc - tedge;
        tedge = cyc;
      end else if (ps && !scl_bus) begin
        if (bc == 2) hw = cyc - tedge;
        tedge = cyc;
        if (bc == 8) begin
          drv = 0;
          if (is_addr) begin
            addr_seen = shreg; s_sel = (shreg[7:1] == SLV); s_rd = shreg[0]; slv_lo <= s_sel;
          end else if (!s_rd) begin
            last_rx = shreg; slv_lo <= s_sel && !nack_data;
          end else slv_lo <= 1'b0;
        end else if (bc == 9) begin
          bc = 0;
          if (s_sel && s_rd && (is_addr || !mnack)) begin
            if (!is_addr) rd_k++;
            txb = rdb(rd_k); drv = 1; slv_lo <= !txb[7];
          end else begin
            drv = 0; slv_lo <= 1'b0;
          end
          is_addr = 0;
        end else if (bc >= 1 && bc <= 7 && drv) slv_lo <= !txb[7 - bc];
      end
      ps = scl_bus; pd = sda_bus;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(input logic [7:0] v);
    @(negedge clk); wr_ctl = 1'b1; wdata = v;
    @(negedge clk); wr_ctl = 1'b0;
  endtask

  task automatic dat_wr(input logic [7:0] v);
    @(negedge clk); wr_data = 1'b1; wdata = v;
    @(negedge clk); wr_data = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!ctl_q[3] && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk({req, " step flag timeout"}, 0, 1);
  endtask

  task automatic wait_stop(input string req);
    int n = 0;
    while (ctl_q[4] && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk({req, " stop timeout"}, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stat", stat_q, 8'hF8);
    chk("R1 ctl", ctl_q, 0);
    chk("R1 data", data_q, 0);
    chk("R1 lines/irq", {irq, scl_lo, sda_lo}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: start bit without enable does nothing
    ctl_wr(8'h20);
    repeat (40) @(negedge clk);
    chk("R11 no-enable stat", stat_q, 8'hF8);
    chk("R11 no-enable lines", {ctl_q[3], scl_lo, sda_lo}, 0);

    // R10: start refused while the data line is held low
    hold_sda_low = 1'b1;
    ctl_wr(8'h60);
    repeat (40) @(negedge clk);
    chk("R10 refused stat", stat_q, 8'hF8);
    chk("R10 refused flag/lines", {ctl_q[3], scl_lo, sda_lo}, 3'b100);
    hold_sda_low = 1'b0;

    // R2 / R9: START
    irq_en = 1'b1;
    ctl_wr(8'h60); wait_flag("R2");
    chk("R2 start code", stat_q, 8'h08);
    chk("R2 clock held low", scl_lo, 1);
    chk("R9 irq on", irq, 1);

    // R4: write address, acknowledged
    dat_wr({SLV, 1'b0}); ctl_wr(8'h40); wait_flag("R4");
    chk("R4 write addr code", stat_q, exp_code(1, 0, 1));
    chk("R4 addr on bus", addr_seen, {SLV, 1'b0});

    // R5 / R12 / R13 / R11: data bytes
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d;
      d = 8'(k * 8'h2B) ^ 8'h91;
      dat_wr(d); ctl_wr(8'h40);
      if (k == 3) begin
        dat_wr(8'h00); ctl_wr(8'h60);   // R12: ignored while busy
      end
      wait_flag("R5");
      chk("R5 data code", stat_q, exp_code(0, 0, 1));
      chk("R5 byte on bus", last_rx, d);
      if (k == 3) chk("R12 data kept", data_q, d);
      if (k == 2) begin
        chk("R13 high width", hw, HALF * TDIV);
        chk("R13 low width", lw, HALF * TDIV);
      end
    end
    ctl_wr(8'h48);   // R11: flag bit written as 1
    repeat (60) @(negedge clk);
    chk("R11 flag-set write", {ctl_q[3], stat_q}, {1'b1, 8'h28});

    // R6: data NACK
    nack_data = 1'b1;
    dat_wr(8'h77); ctl_wr(8'h40); wait_flag("R6");
    chk("R6 data nack code", stat_q, exp_code(0, 0, 0));
    nack_data = 1'b0;

    // R3: repeated START, then R4 read address
    ctl_wr(8'h60); wait_flag("R3");
    chk("R3 restart code", stat_q, 8'h10);
    dat_wr({SLV, 1'b1}); ctl_wr(8'h40); wait_flag("R4");
    chk("R4 read addr code", stat_q, exp_code(1, 1, 1));

    // R7: read bytes, last one NACKed by the master
    for (int j = 0; j < 4; j++) begin
      ctl_wr(j < 3 ? 8'h44 : 8'h40); wait_flag("R7");
      chk("R7 read data", data_q, rdb(j));
      chk("R7 read code", stat_q, exp_code(0, 1, j < 3));
    end

    // R8 / R9: STOP
    ctl_wr(8'h50); wait_stop("R8");
    chk("R8 stop code", stat_q, 8'hF8);
    chk("R8 lines released", {scl_lo, sda_lo, ctl_q[4]}, 0);
    chk("R9 irq off", irq, 0);

    // R6: address NACKs for write and read
    ctl_wr(8'h60); wait_flag("R6");
    dat_wr({7'h12, 1'b0}); ctl_wr(8'h40); wait_flag("R6");
    chk("R6 write addr nack", stat_q, exp_code(1, 0, 0));
    ctl_wr(8'h60); wait_flag("R6");
    dat_wr({7'h12, 1'b1}); ctl_wr(8'h40); wait_flag("R6");
    chk("R6 read addr nack", stat_q, exp_code(1, 1, 0));
    ctl_wr(8'h50); wait_stop("R8");
    chk("R8 second stop", stat_q, 8'hF8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule